// File: doc/BRIEF.md
# Non-blocking Instruction Line Cache

This block sits between instruction fetch and the next memory level. Fetch presents one lookup per cycle as an address, a requester tag and a demand flag. The cache searches a set-associative, read-only array and answers in the following cycle. A hit carries the whole line. A miss produces a miss notice at once. A demand miss is then tracked by a small pool of miss status holding registers (MSHRs), and the fill data comes back later on the same response port, marked as a fill.

Misses do not block. Several lines may be in flight at once, and a second miss to a line that is already outstanding joins the existing entry rather than sending another downstream request. A kill input lets fetch drop every replay it is still waiting on. The line fetches that are already under way still finish and are written into the array, so the work is not wasted.

Top module: `icl_fetch_cache`

## Requirements
- R1: A lookup that hits is answered in the cycle after acceptance with rsp_valid=1, rsp_hit=1, rsp_fill=0, the request's rsp_id and the full line in rsp_data.
- R2: A lookup that misses is answered in the cycle after acceptance with rsp_valid=1, rsp_hit=0, rsp_fill=0. A demand miss on a line not already outstanding claims a free MSHR, which raises mem_req_valid with the line address (the request address without its offset bits) and mem_req_tag set to the entry number. mem_req_valid stays high until it is taken.
- R3: A mem_rsp_valid cycle writes the returned line into the array in that same cycle. Every requester still waiting on that entry then receives a response with rsp_fill=1, rsp_hit=0 and the line data, one per cycle, lowest rsp_id first. Later lookups of that line hit.
- R4: A miss with req_demand=0 issues no downstream request and fills nothing, so a later demand lookup of the same line still misses.
- R5: A demand miss to a line that an MSHR already holds issues no further downstream request. Both requesters get their own fill response.
- R6: While every MSHR is busy, req_ready is 0 for a demand miss that would need a new entry. It returns to 1 once an entry frees.
- R7: A kill pulse removes every pending fill response, including one for a miss accepted in the same cycle. The outstanding fetch still completes, so the line hits afterwards.
- R8: Address fields: offset is the low log2(LINE_BYTES) bits, set index is the next log2(SETS) bits, and the tag is the remainder. A fill goes to the lowest-numbered invalid way of the set, or otherwise to the way chosen by a per-set tree pseudo-LRU. The pseudo-LRU is updated on every hit and every fill.
- R9: A lookup accepted in the same cycle as a refill is answered first. Fill responses follow in the next cycles, and req_ready stays 0 while any fill response is waiting.
- R10: After reset, rsp_valid=0, mem_req_valid=0 and req_ready=1, and the array holds no valid lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup can be accepted this cycle |
| req_addr | input | ADDR_W | Byte address of the lookup |
| req_id | input | ID_W | Requester tag, returned with the response |
| req_demand | input | 1 | 1 = demand lookup, allowed to fill |
| kill | input | 1 | Drop all pending fill responses |
| rsp_valid | output | 1 | Response present |
| rsp_id | output | ID_W | Tag of the answered request |
| rsp_hit | output | 1 | Lookup hit |
| rsp_fill | output | 1 | Response delivers refilled data |
| rsp_data | output | 8*LINE_BYTES | Line data (zero on a miss notice) |
| mem_req_valid | output | 1 | Line request to next level |
| mem_req_ready | input | 1 | Next level accepts the line request |
| mem_req_addr | output | ADDR_W-log2(LINE_BYTES) | Line address requested |
| mem_req_tag | output | log2(MSHRS) | MSHR number of the request |
| mem_rsp_valid | input | 1 | Refill data present |
| mem_rsp_tag | input | log2(MSHRS) | MSHR number being refilled |
| mem_rsp_data | input | 8*LINE_BYTES | Refill line |

## Verification
A hit answer and a fill answer compete for the one response port when a lookup is accepted on the same clock edge as a refill. The bench causes this by driving a hit request and mem_rsp_valid at the same edge. It then expects the hit response first and the fill response exactly one cycle later, and it expects req_ready low in between. A kill that lands while a miss is outstanding is judged the same way: the fill response must never appear, and a later lookup of that line must hit.

// File: rtl/icl_pkg.sv
package icl_pkg;
   typedef enum logic [1:0] {
      MS_IDLE  = 2'd0,
      MS_ISSUE = 2'd1,
      MS_WAIT  = 2'd2,
      MS_DONE  = 2'd3
   } mshr_state_e;
endpackage

// File: rtl/icl_tag_store.sv
module icl_tag_store #(
   parameter int SETS   = 8,
   parameter int WAYS   = 2,
   parameter int TAG_W  = 10,
   parameter int LINE_W = 64,
   localparam int IDX_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  lk_idx,
   input  logic [TAG_W-1:0]  lk_tag,
   output logic              lk_hit,
   output logic [WAY_W-1:0]  lk_way,
   output logic [LINE_W-1:0] lk_data,
   input  logic              touch_en,
   input  logic [IDX_W-1:0]  touch_idx,
   input  logic [WAY_W-1:0]  touch_way,
   input  logic              fill_en,
   input  logic [IDX_W-1:0]  fill_idx,
   input  logic [TAG_W-1:0]  fill_tag,
   input  logic [LINE_W-1:0] fill_data
);
   localparam int TREE_N = WAYS - 1;

   logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
   logic [LINE_W-1:0] dat_q  [SETS][WAYS];
   logic [WAYS-1:0]   vld_q  [SETS];
   logic [TREE_N-1:0] plru_q [SETS];
   logic [WAYS-1:0]   way_match;
   logic [WAY_W-1:0]  fill_way;

   function automatic logic [WAY_W-1:0] plru_victim(input logic [TREE_N-1:0] t);
      int node;
      node = 0;
      for (int l = 0; l < WAY_W; l++) node = 2 * node + 1 + int'(t[node]);
      return WAY_W'(node - TREE_N);
   endfunction

   function automatic logic [TREE_N-1:0] plru_touch(input logic [TREE_N-1:0] t,
                                                     input logic [WAY_W-1:0] w);
      logic [TREE_N-1:0] r;
      int node;
      logic b;
      r = t;
      node = 0;
      for (int l = WAY_W - 1; l >= 0; l--) begin
         b = w[l];
         r[node] = ~b;
         node = 2 * node + 1 + int'(b);
      end
      return r;
   endfunction

   for (genvar w = 0; w < WAYS; w++) begin : g_way_cmp
      assign way_match[w] = vld_q[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag);
   end

   assign lk_hit = |way_match;

   always_comb begin
      lk_way = '0;
      for (int w = 0; w < WAYS; w++) if (way_match[w]) lk_way = WAY_W'(w);
   end

   assign lk_data = dat_q[lk_idx][lk_way];

   always_comb begin
      fill_way = plru_victim(plru_q[fill_idx]);
      for (int w = WAYS - 1; w >= 0; w--) if (!vld_q[fill_idx][w]) fill_way = WAY_W'(w);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            vld_q[s]  <= '0;
            plru_q[s] <= '0;
         end
      end else begin
         if (touch_en) plru_q[touch_idx] <= plru_touch(plru_q[touch_idx], touch_way);
         if (fill_en) begin
            vld_q[fill_idx][fill_way] <= 1'b1;
            plru_q[fill_idx] <= plru_touch(plru_q[fill_idx], fill_way);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (fill_en) begin
         tag_q[fill_idx][fill_way] <= fill_tag;
         dat_q[fill_idx][fill_way] <= fill_data;
      end
   end

   assert_touch_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      touch_en |-> vld_q[touch_idx][touch_way]);

   assert_single_way_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(way_match));
endmodule

// File: rtl/icl_mshr_file.sv
module icl_mshr_file #(
   parameter int ENTRIES = 4,
   parameter int LADDR_W = 13,
   parameter int ID_W    = 2,
   parameter int LINE_W  = 64,
   localparam int E_W    = $clog2(ENTRIES),
   localparam int IDS    = 1 << ID_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               kill,
   input  logic [LADDR_W-1:0] q_laddr,
   input  logic [ID_W-1:0]    q_id,
   output logic               q_match,
   output logic               q_full,
   input  logic               alloc_en,
   input  logic               merge_en,
   output logic               mem_req_valid,
   input  logic               mem_req_ready,
   output logic [LADDR_W-1:0] mem_req_laddr,
   output logic [E_W-1:0]     mem_req_tag,
   input  logic               mem_rsp_valid,
   input  logic [E_W-1:0]     mem_rsp_tag,
   input  logic [LINE_W-1:0]  mem_rsp_data,
   output logic               fill_en,
   output logic [LADDR_W-1:0] fill_laddr,
   output logic [LINE_W-1:0]  fill_data,
   output logic               drn_pending,
   output logic [ID_W-1:0]    drn_id,
   output logic [LINE_W-1:0]  drn_data,
   input  logic               drn_take
);
   import icl_pkg::*;

   mshr_state_e        st_w [ENTRIES];
   logic [LADDR_W-1:0] la_w [ENTRIES];
   logic [IDS-1:0]     wt_w [ENTRIES];
   logic [LINE_W-1:0]  dt_w [ENTRIES];
   logic [ENTRIES-1:0] hit_vec, free_vec, iss_vec, drn_vec, wt_any_vec;
   logic [E_W-1:0]     match_idx, alloc_idx, iss_idx, drn_idx;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      mshr_state_e        st_q, st_d;
      logic [LADDR_W-1:0] la_q;
      logic [IDS-1:0]     wt_q, wt_d;
      logic [LINE_W-1:0]  dt_q;

      assign st_w[e] = st_q;
      assign la_w[e] = la_q;
      assign wt_w[e] = wt_q;
      assign dt_w[e] = dt_q;
      assign hit_vec[e]    = (st_q != MS_IDLE) && (la_q == q_laddr);
      assign free_vec[e]   = (st_q == MS_IDLE);
      assign iss_vec[e]    = (st_q == MS_ISSUE);
      assign drn_vec[e]    = (st_q == MS_DONE) && (|wt_q);
      assign wt_any_vec[e] = |wt_q;

      always_comb begin
         st_d = st_q;
         wt_d = wt_q;
         if (drn_take && drn_idx == E_W'(e)) wt_d[drn_id] = 1'b0;
         if (alloc_en && alloc_idx == E_W'(e)) begin
            st_d = MS_ISSUE;
            wt_d = '0;
            wt_d[q_id] = 1'b1;
         end
         if (merge_en && match_idx == E_W'(e)) wt_d[q_id] = 1'b1;
         if (mem_req_valid && mem_req_ready && iss_idx == E_W'(e)) st_d = MS_WAIT;
         if (mem_rsp_valid && mem_rsp_tag == E_W'(e)) st_d = MS_DONE;
         if (kill) wt_d = '0;
         if (st_d == MS_DONE && wt_d == '0) st_d = MS_IDLE;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_q <= MS_IDLE;
            wt_q <= '0;
         end else begin
            st_q <= st_d;
            wt_q <= wt_d;
         end
      end

      always_ff @(posedge clk) begin
         if (alloc_en && alloc_idx == E_W'(e)) la_q <= q_laddr;
         if (mem_rsp_valid && mem_rsp_tag == E_W'(e)) dt_q <= mem_rsp_data;
      end
   end

   always_comb begin
      match_idx = '0;
      alloc_idx = '0;
      iss_idx   = '0;
      drn_idx   = '0;
      for (int e = ENTRIES - 1; e >= 0; e--) begin
         if (hit_vec[e])  match_idx = E_W'(e);
         if (free_vec[e]) alloc_idx = E_W'(e);
         if (iss_vec[e])  iss_idx   = E_W'(e);
         if (drn_vec[e])  drn_idx   = E_W'(e);
      end
   end

   always_comb begin
      drn_id = '0;
      for (int i = IDS - 1; i >= 0; i--) if (wt_w[drn_idx][i]) drn_id = ID_W'(i);
   end

   assign q_match       = |hit_vec;
   assign q_full        = ~|free_vec;
   assign mem_req_valid = |iss_vec;
   assign mem_req_laddr = la_w[iss_idx];
   assign mem_req_tag   = iss_idx;
   assign fill_en       = mem_rsp_valid;
   assign fill_laddr    = la_w[mem_rsp_tag];
   assign fill_data     = mem_rsp_data;
   assign drn_pending   = |drn_vec;
   assign drn_data      = dt_w[drn_idx];

   assert_alloc_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_en |-> !q_full);

   assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> mem_req_valid);

   assert_refill_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rsp_valid |-> (st_w[mem_rsp_tag] == MS_WAIT));

   assert_one_entry_per_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(hit_vec) <= 1);

   assert_kill_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      kill |=> (wt_any_vec == '0));
endmodule

// File: rtl/icl_fetch_cache.sv
module icl_fetch_cache #(
   parameter int ADDR_W     = 16,
   parameter int LINE_BYTES = 8,
   parameter int SETS       = 8,
   parameter int WAYS       = 2,
   parameter int MSHRS      = 4,
   parameter int ID_W       = 2,
   localparam int OFF_W     = $clog2(LINE_BYTES),
   localparam int LINE_W    = 8 * LINE_BYTES,
   localparam int IDX_W     = $clog2(SETS),
   localparam int WAY_W     = $clog2(WAYS),
   localparam int LADDR_W   = ADDR_W - OFF_W,
   localparam int TAG_W     = LADDR_W - IDX_W,
   localparam int E_W       = $clog2(MSHRS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [ID_W-1:0]    req_id,
   input  logic               req_demand,
   input  logic               kill,
   output logic               rsp_valid,
   output logic [ID_W-1:0]    rsp_id,
   output logic               rsp_hit,
   output logic               rsp_fill,
   output logic [LINE_W-1:0]  rsp_data,
   output logic               mem_req_valid,
   input  logic               mem_req_ready,
   output logic [LADDR_W-1:0] mem_req_addr,
   output logic [E_W-1:0]     mem_req_tag,
   input  logic               mem_rsp_valid,
   input  logic [E_W-1:0]     mem_rsp_tag,
   input  logic [LINE_W-1:0]  mem_rsp_data
);
   if (LINE_BYTES < 2 || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
      $error("LINE_BYTES must be a power of two of at least 2");
   end
   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("SETS must be a power of two of at least 2");
   end
   if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      $error("WAYS must be a power of two of at least 2");
   end
   if (MSHRS < 2 || (MSHRS & (MSHRS - 1)) != 0) begin : g_bad_mshr
      $error("MSHRS must be a power of two of at least 2");
   end
   if (TAG_W < 1 || ID_W < 1) begin : g_bad_addr
      $error("address too narrow for the geometry, or ID_W below 1");
   end

   logic [LADDR_W-1:0] laddr, fill_laddr;
   logic [IDX_W-1:0]   idx;
   logic [TAG_W-1:0]   tag;
   logic               lk_hit, q_match, q_full, drn_pending, drn_take, fill_en;
   logic [WAY_W-1:0]   lk_way;
   logic [LINE_W-1:0]  lk_data, drn_data, fill_data;
   logic [ID_W-1:0]    drn_id;
   logic               need_alloc, req_fire, alloc_en, merge_en;

   assign laddr = req_addr[ADDR_W-1:OFF_W];
   assign idx   = laddr[IDX_W-1:0];
   assign tag   = laddr[LADDR_W-1:IDX_W];

   icl_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .LINE_W(LINE_W)) tags_i (
      .clk(clk), .rst_n(rst_n),
      .lk_idx(idx), .lk_tag(tag), .lk_hit(lk_hit), .lk_way(lk_way), .lk_data(lk_data),
      .touch_en(req_fire && lk_hit), .touch_idx(idx), .touch_way(lk_way),
      .fill_en(fill_en), .fill_idx(fill_laddr[IDX_W-1:0]),
      .fill_tag(fill_laddr[LADDR_W-1:IDX_W]), .fill_data(fill_data)
   );

   icl_mshr_file #(.ENTRIES(MSHRS), .LADDR_W(LADDR_W), .ID_W(ID_W), .LINE_W(LINE_W)) mshr_i (
      .clk(clk), .rst_n(rst_n), .kill(kill),
      .q_laddr(laddr), .q_id(req_id), .q_match(q_match), .q_full(q_full),
      .alloc_en(alloc_en), .merge_en(merge_en),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_laddr(mem_req_addr), .mem_req_tag(mem_req_tag),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_tag(mem_rsp_tag), .mem_rsp_data(mem_rsp_data),
      .fill_en(fill_en), .fill_laddr(fill_laddr), .fill_data(fill_data),
      .drn_pending(drn_pending), .drn_id(drn_id), .drn_data(drn_data), .drn_take(drn_take)
   );

   assign need_alloc = !lk_hit && req_demand && !q_match;
   assign req_ready  = !drn_pending && !(need_alloc && q_full);
   assign req_fire   = req_valid && req_ready;
   assign alloc_en   = req_fire && need_alloc;
   assign merge_en   = req_fire && !lk_hit && req_demand && q_match;
   assign drn_take   = !req_fire && drn_pending && !kill;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_id    <= '0;
         rsp_hit   <= 1'b0;
         rsp_fill  <= 1'b0;
         rsp_data  <= '0;
      end else if (req_fire) begin
         rsp_valid <= 1'b1;
         rsp_id    <= req_id;
         rsp_hit   <= lk_hit;
         rsp_fill  <= 1'b0;
         rsp_data  <= lk_hit ? lk_data : '0;
      end else if (drn_take) begin
         rsp_valid <= 1'b1;
         rsp_id    <= drn_id;
         rsp_hit   <= 1'b0;
         rsp_fill  <= 1'b1;
         rsp_data  <= drn_data;
      end else begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_fill  <= 1'b0;
      end
   end

   assert_hit_reply_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_fire && lk_hit) |=> (rsp_valid && rsp_hit && rsp_id == $past(req_id)));

   assert_miss_notice_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_fire && !lk_hit) |=> (rsp_valid && !rsp_hit && !rsp_fill));

   assert_kind_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !(rsp_hit && rsp_fill));

   assert_no_lookup_during_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
      drn_pending |-> !req_fire);
endmodule

// File: tb/icl_fetch_cache_tb_top.sv
`timescale 1ns/1ps
module icl_fetch_cache_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [15:0] req_addr = '0;
   logic [1:0]  req_id = '0;
   logic        req_demand = 1'b0;
   logic        kill = 1'b0;
   logic        rsp_valid, rsp_hit, rsp_fill;
   logic [1:0]  rsp_id;
   logic [63:0] rsp_data;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b1;
   logic [12:0] mem_req_addr;
   logic [1:0]  mem_req_tag;
   logic        mem_rsp_valid = 1'b0;
   logic [1:0]  mem_rsp_tag = '0;
   logic [63:0] mem_rsp_data = '0;

   int n_run = 0;
   int n_fail = 0;
   int cyc = 0;

   logic [1:0]  rl_id   [256];
   logic        rl_hit  [256];
   logic        rl_fill [256];
   logic [63:0] rl_data [256];
   int          rl_cyc  [256];
   int          rl_n = 0;
   logic [12:0] mq_addr [64];
   logic [1:0]  mq_tag  [64];
   int          mq_n = 0;

   icl_fetch_cache dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_id(req_id), .req_demand(req_demand), .kill(kill),
      .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_hit(rsp_hit), .rsp_fill(rsp_fill),
      .rsp_data(rsp_data), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_req_tag(mem_req_tag),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_tag(mem_rsp_tag), .mem_rsp_data(mem_rsp_data)
   );

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rst_n && rsp_valid && rl_n < 256) begin
         rl_id[rl_n]   = rsp_id;
         rl_hit[rl_n]  = rsp_hit;
         rl_fill[rl_n] = rsp_fill;
         rl_data[rl_n] = rsp_data;
         rl_cyc[rl_n]  = cyc;
         rl_n = rl_n + 1;
      end
      if (rst_n && mem_req_valid && mem_req_ready && mq_n < 64) begin
         mq_addr[mq_n] = mem_req_addr;
         mq_tag[mq_n]  = mem_req_tag;
         mq_n = mq_n + 1;
      end
   end

   function automatic logic [63:0] mem_line(input logic [12:0] la);
      return {16'hF00D, 3'b000, la, ~{3'b000, la}, 16'h1234 ^ {3'b000, la}};
   endfunction

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
      #1;
   endtask

   task automatic send(input logic [15:0] a, input logic [1:0] id, input bit dem);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_id = id; req_demand = dem;
      #1;
      while (!req_ready) begin @(negedge clk); #1; end
      @(posedge clk); #1;
      req_valid = 1'b0;
   endtask

   task automatic refill(input int k);
      @(negedge clk);
      mem_rsp_valid = 1'b1; mem_rsp_tag = mq_tag[k]; mem_rsp_data = mem_line(mq_addr[k]);
      @(negedge clk);
      mem_rsp_valid = 1'b0;
   endtask

   localparam int NV = 11;
   // {address, demand, expected hit}
   localparam logic [17:0] VEC [NV] = '{
      {16'h0040, 1'b1, 1'b0}, {16'h0044, 1'b1, 1'b1}, {16'h0080, 1'b1, 1'b0},
      {16'h00C0, 1'b1, 1'b0}, {16'h0080, 1'b1, 1'b1}, {16'h0040, 1'b1, 1'b0},
      {16'h0080, 1'b1, 1'b1}, {16'h0108, 1'b0, 1'b0}, {16'h0108, 1'b1, 1'b0},
      {16'h010C, 1'b1, 1'b1}, {16'h00C0, 1'b1, 1'b0}
   };

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not complete actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      int base, mbase;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      // R10 reset state
      check(req_ready == 1'b1, "R10 ready after reset", req_ready, 1);
      check(rsp_valid == 1'b0, "R10 no response after reset", rsp_valid, 0);
      check(mem_req_valid == 1'b0, "R10 no line request after reset", mem_req_valid, 0);

      // Table walk: R1 hits, R2/R3 miss and refill, R4 non-demand, R8 placement
      for (int v = 0; v < NV; v++) begin
         logic [15:0] a;
         logic dem, eh;
         a = VEC[v][17:2]; dem = VEC[v][1]; eh = VEC[v][0];
         base = rl_n; mbase = mq_n;
         send(a, 2'd0, dem);
         settle();
         check(rl_n == base + 1, "R1/R2 one response per lookup", rl_n - base, 1);
         check(rl_hit[base] == eh, "R1/R2/R4/R8 hit flag", rl_hit[base], eh);
         check(rl_fill[base] == 1'b0, "R2 lookup answer not a fill", rl_fill[base], 0);
         if (eh)
            check(rl_data[base] == mem_line(a[15:3]), "R1 hit data", rl_data[base], mem_line(a[15:3]));
         check(mq_n - mbase == ((!eh && dem) ? 1 : 0), "R2/R4 downstream request count",
               mq_n - mbase, (!eh && dem) ? 1 : 0);
         if (!eh && dem) begin
            check(mq_addr[mbase] == a[15:3], "R2 line address", mq_addr[mbase], a[15:3]);
            refill(mbase);
            settle();
            check(rl_n == base + 2 && rl_fill[base + 1] == 1'b1 && rl_hit[base + 1] == 1'b0,
                  "R3 fill response on shared port", rl_n - base, 2);
            check(rl_data[base + 1] == mem_line(a[15:3]), "R3 fill data",
                  rl_data[base + 1], mem_line(a[15:3]));
         end
      end

      // R5 merge of two misses to one line
      base = rl_n; mbase = mq_n;
      send(16'h0210, 2'd1, 1'b1);
      send(16'h0214, 2'd2, 1'b1);
      settle();
      check(mq_n - mbase == 1, "R5 single downstream request", mq_n - mbase, 1);
      refill(mbase);
      settle();
      check(rl_n == base + 4, "R5 two notices plus two fills", rl_n - base, 4);
      check(rl_fill[base + 2] && rl_id[base + 2] == 2'd1, "R5 first fill id", rl_id[base + 2], 1);
      check(rl_fill[base + 3] && rl_id[base + 3] == 2'd2, "R5 second fill id", rl_id[base + 3], 2);
      check(rl_cyc[base + 3] - rl_cyc[base + 2] == 1, "R3 fills one per cycle",
            rl_cyc[base + 3] - rl_cyc[base + 2], 1);
      check(rl_data[base + 3] == mem_line(13'h042), "R5 merged fill data",
            rl_data[base + 3], mem_line(13'h042));

      // R6 all entries busy
      base = rl_n; mbase = mq_n;
      for (int i = 0; i < 4; i++) send(16'h1018 + 16'(i) * 16'h1000, 2'(i), 1'b1);
      settle();
      check(mq_n - mbase == 4, "R6 four entries in flight", mq_n - mbase, 4);
      @(negedge clk);
      req_valid = 1'b1; req_addr = 16'h5018; req_id = 2'd0; req_demand = 1'b1;
      #1;
      check(req_ready == 1'b0, "R6 ready low when full", req_ready, 0);
      refill(mbase);
      #1;
      while (!req_ready) begin @(negedge clk); #1; end
      @(posedge clk); #1;
      req_valid = 1'b0;
      settle();
      check(mq_n - mbase == 5, "R6 held miss issued after entry frees", mq_n - mbase, 5);
      for (int k = 1; k < 5; k++) refill(mbase + k);
      settle();
      check(rl_n - base == 10, "R6 every requester answered", rl_n - base, 10);

      // R7 kill squashes replay but fill still lands
      base = rl_n; mbase = mq_n;
      send(16'h0620, 2'd3, 1'b1);
      settle();
      @(negedge clk); kill = 1'b1;
      @(negedge clk); kill = 1'b0;
      refill(mbase);
      settle();
      check(rl_n == base + 1, "R7 no fill response after kill", rl_n - base, 1);
      send(16'h0620, 2'd3, 1'b1);
      settle();
      check(rl_hit[base + 1] == 1'b1, "R7 killed line still filled", rl_hit[base + 1], 1);
      check(rl_data[base + 1] == mem_line(13'h0C4), "R7 filled data",
            rl_data[base + 1], mem_line(13'h0C4));

      // R9 hit lookup and refill on the same edge
      base = rl_n; mbase = mq_n;
      send(16'h0730, 2'd0, 1'b1);
      settle();
      @(negedge clk);
      req_valid = 1'b1; req_addr = 16'h0080; req_id = 2'd2; req_demand = 1'b1;
      mem_rsp_valid = 1'b1; mem_rsp_tag = mq_tag[mbase]; mem_rsp_data = mem_line(mq_addr[mbase]);
      #1;
      check(req_ready == 1'b1, "R9 lookup accepted in refill cycle", req_ready, 1);
      @(negedge clk);
      req_valid = 1'b0; mem_rsp_valid = 1'b0;
      #1;
      check(req_ready == 1'b0, "R9 ready low while fill pending", req_ready, 0);
      settle();
      check(rl_n == base + 3, "R9 both responses delivered", rl_n - base, 3);
      check(rl_hit[base + 1] && rl_id[base + 1] == 2'd2, "R9 hit answered first",
            rl_id[base + 1], 2);
      check(rl_fill[base + 2] && rl_id[base + 2] == 2'd0, "R9 fill answered second",
            rl_id[base + 2], 0);
      check(rl_cyc[base + 2] - rl_cyc[base + 1] == 1, "R9 fill one cycle after hit",
            rl_cyc[base + 2] - rl_cyc[base + 1], 1);
      check(rl_data[base + 2] == mem_line(13'h0E6), "R9 fill data",
            rl_data[base + 2], mem_line(13'h0E6));

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule